// File: doc/BRIEF.md
# Masked Local-Bus Interrupt Encoder

This block gathers sixteen level-sensitive interrupt lines from local-bus peripherals into one interrupt request. Every clock, each line is sampled into its own bit of a source register: a high level sets the bit and a low level clears it. A software-writable enable mask gates the source bits. The single request output stays high for as long as any enabled source bit is set.

Software reaches the block through a 16-bit register port with byte offsets. The mask register sits at offset 0x02, and software can read it and write it. The read-only vector register at offset 0x00 gives the lowest-numbered pending line in encoded form. An interrupt handler can use that value directly as a word-aligned table offset. The value 0 means that no line is pending.

Priority between lines is fixed. The block does no edge detection and no nesting.

Top module: `lbus_irq_encoder`

## Requirements
- R1: Each clock edge loads line k into source bit k. A line that goes low clears its bit at the next edge, with no latching.
- R2: A line is pending when its source bit and its mask bit are both 1. `irqOut` is high exactly when at least one line is pending. A line whose mask bit is 0 never raises `irqOut`.
- R3: A read of offset 0x00 returns ((i+1) << 2), where i is the lowest-numbered pending line. Line 0 gives 4 and line 15 gives 64. Bits [1:0] of the result are always 0.
- R4: A read of offset 0x00 returns 0 when no line is pending.
- R5: A write to offset 0x02 loads the mask from `busWrData`. A read of offset 0x02 returns the mask. `irqOut` and the vector reflect a new mask value in the cycle right after the write edge.
- R6: While reset is asserted and directly after it, the mask is 0x0010, the source register is 0, and `irqOut` is low.
- R7: A read of any offset other than 0x00 and 0x02 returns 0. This includes the odd offsets 0x01 and 0x03.
- R8: A write to any offset other than 0x02 changes neither the mask nor the vector.
- R9: `busRdData` is 0 in every cycle in which `busRdEn` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineIn | input | NUM_LINES (16) | Level-sensitive interrupt lines, synchronous to clk |
| busAddr | input | ADDR_W (12) | Byte offset of the register access |
| busWrEn | input | 1 | Write strobe, acted on at the clock edge |
| busWrData | input | DATA_W (16) | Write data |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | DATA_W (16) | Read data, combinational from the address while busRdEn is high |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its defaults: 16 lines, a 16-bit data port and a 12-bit offset. With 16 lines, line 15 is reachable, which gives the largest vector code, 64. Line 0 gives the smallest code, 4. With a 12-bit offset, accesses can reach unmapped and odd offsets inside the window. Random line patterns mixed with mask rewrites cover masked-only, multi-pending and empty states. Directed cases cover the reset mask and the single-line boundary cases.

// File: rtl/irqenc_pkg.sv
package irqenc_pkg;

  // Strobes sent from the access decoder to the datapath
  typedef struct packed {
    logic maskWr;  // load the enable mask this edge
    logic rdVec;   // drive the encoded vector onto read data
    logic rdMask;  // drive the enable mask onto read data
  } irqenc_strb_t;

endpackage

// File: rtl/irqenc_ctrl.sv
module irqenc_ctrl
  import irqenc_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned VEC_OFS  = 0,
  parameter int unsigned MASK_OFS = 2
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output irqenc_strb_t      strb
);

  localparam logic [ADDR_W-1:0] VecAddr  = ADDR_W'(VEC_OFS);
  localparam logic [ADDR_W-1:0] MaskAddr = ADDR_W'(MASK_OFS);

  logic hitVec;
  logic hitMask;

  // The full offset is compared, so odd and aliased offsets decode as unmapped
  assign hitVec  = (busAddr == VecAddr);
  assign hitMask = (busAddr == MaskAddr);

  always_comb begin
    strb        = '0;
    strb.maskWr = busWrEn & hitMask;
    strb.rdVec  = busRdEn & hitVec;
    strb.rdMask = busRdEn & hitMask;
  end

endmodule

// File: rtl/irqenc_datapath.sv
module irqenc_datapath
  import irqenc_pkg::*;
#(
  parameter int unsigned NUM_LINES = 16,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned MASK_RST  = 32'h0010,
  parameter int unsigned VEC_SHIFT = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] lineIn,
  input  logic [DATA_W-1:0]    busWrData,
  input  irqenc_strb_t         strb,
  output logic [DATA_W-1:0]    rdData,
  output logic                 irqOut,
  output logic [NUM_LINES-1:0] srcBits,
  output logic [NUM_LINES-1:0] maskBits
);

  localparam logic [NUM_LINES-1:0] MaskInit = NUM_LINES'(MASK_RST);

  logic [NUM_LINES-1:0] pendBits;
  logic [DATA_W-1:0]    vecCode;

  // One source flop per line, each following its line level
  for (genvar g = 0; g < NUM_LINES; g++) begin : gSrc
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) srcBits[g] <= 1'b0;
      else       srcBits[g] <= lineIn[g];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            maskBits <= MaskInit;
    else if (strb.maskWr) maskBits <= busWrData[NUM_LINES-1:0];
  end

  assign pendBits = srcBits & maskBits;
  assign irqOut   = |pendBits;

  // Fixed priority: scanning downward leaves the lowest set index in place
  always_comb begin
    vecCode = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (pendBits[i]) vecCode = DATA_W'((i + 1) << VEC_SHIFT);
    end
  end

  always_comb begin
    if (strb.rdVec)       rdData = vecCode;
    else if (strb.rdMask) rdData = DATA_W'(maskBits);
    else                  rdData = '0;
  end

endmodule

// File: rtl/lbus_irq_encoder.sv
module lbus_irq_encoder
  import irqenc_pkg::*;
#(
  parameter int unsigned NUM_LINES = 16,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned VEC_OFS   = 0,
  parameter int unsigned MASK_OFS  = 2,
  parameter int unsigned MASK_RST  = 32'h0010,
  parameter int unsigned VEC_SHIFT = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] lineIn,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrEn,
  input  logic [DATA_W-1:0]    busWrData,
  input  logic                 busRdEn,
  output logic [DATA_W-1:0]    busRdData,
  output logic                 irqOut
);

  irqenc_strb_t         strb;
  logic [NUM_LINES-1:0] srcBits;
  logic [NUM_LINES-1:0] maskBits;

  irqenc_ctrl #(
    .ADDR_W  (ADDR_W),
    .VEC_OFS (VEC_OFS),
    .MASK_OFS(MASK_OFS)
  ) uCtrl (
    .busAddr(busAddr),
    .busWrEn(busWrEn),
    .busRdEn(busRdEn),
    .strb   (strb)
  );

  irqenc_datapath #(
    .NUM_LINES(NUM_LINES),
    .DATA_W   (DATA_W),
    .MASK_RST (MASK_RST),
    .VEC_SHIFT(VEC_SHIFT)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .lineIn   (lineIn),
    .busWrData(busWrData),
    .strb     (strb),
    .rdData   (busRdData),
    .irqOut   (irqOut),
    .srcBits  (srcBits),
    .maskBits (maskBits)
  );

endmodule

// File: rtl/irqenc_checker.sv
module irqenc_checker #(
  parameter int unsigned NUM_LINES = 16,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned VEC_OFS   = 0,
  parameter int unsigned MASK_OFS  = 2,
  parameter int unsigned MASK_RST  = 32'h0010,
  parameter int unsigned VEC_SHIFT = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_LINES-1:0] lineIn,
  input logic [ADDR_W-1:0]    busAddr,
  input logic                 busWrEn,
  input logic [DATA_W-1:0]    busWrData,
  input logic                 busRdEn,
  input logic [DATA_W-1:0]    busRdData,
  input logic                 irqOut,
  input logic [NUM_LINES-1:0] srcBits,
  input logic [NUM_LINES-1:0] maskBits
);

  localparam logic [ADDR_W-1:0]    VecAddr  = ADDR_W'(VEC_OFS);
  localparam logic [ADDR_W-1:0]    MaskAddr = ADDR_W'(MASK_OFS);
  localparam logic [NUM_LINES-1:0] MaskInit = NUM_LINES'(MASK_RST);
  localparam logic [DATA_W-1:0]    VecMax   = DATA_W'(NUM_LINES << VEC_SHIFT);

  // Set once a clock edge has passed out of reset, so $past sees live values
  logic pastOk;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;
  end

  AST_SRC_FOLLOWS_LINES: assert property (@(posedge clk) disable iff (!rstN)
    pastOk |-> (srcBits == $past(lineIn))); // R1

  AST_IRQ_MATCHES_VEC: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == VecAddr) |-> (irqOut == (busRdData != '0))); // R2

  AST_VEC_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == VecAddr) |-> (busRdData[1:0] == 2'b00 && busRdData <= VecMax)); // R3

  AST_MASK_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == MaskAddr) |=> (maskBits == $past(busWrData[NUM_LINES-1:0]))); // R5

  AST_RESET_STATE: assert property (@(posedge clk)
    !rstN |=> (maskBits == MaskInit && srcBits == '0 && !irqOut)); // R6

  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr != VecAddr && busAddr != MaskAddr) |-> (busRdData == '0)); // R7

  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrEn && busAddr == MaskAddr) |=> $stable(maskBits)); // R8

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |-> (busRdData == '0)); // R9

endmodule

bind lbus_irq_encoder irqenc_checker #(
  .NUM_LINES(NUM_LINES),
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W),
  .VEC_OFS  (VEC_OFS),
  .MASK_OFS (MASK_OFS),
  .MASK_RST (MASK_RST),
  .VEC_SHIFT(VEC_SHIFT)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .lineIn   (lineIn),
  .busAddr  (busAddr),
  .busWrEn  (busWrEn),
  .busWrData(busWrData),
  .busRdEn  (busRdEn),
  .busRdData(busRdData),
  .irqOut   (irqOut),
  .srcBits  (srcBits),
  .maskBits (maskBits)
);

// File: tb/sim_lbus_irq_encoder.sv
`timescale 1ns/1ps
module sim_lbus_irq_encoder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] lineIn = '0;
  logic [11:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [15:0] busWrData = '0;
  logic        busRdEn = 1'b0;
  logic [15:0] busRdData;
  logic        irqOut;

  int checks = 0;
  int fails = 0;
  logic [15:0] expSrc = '0;
  logic [15:0] expMask = 16'h0010;
  logic [15:0] rd;

  always #4 clk = ~clk;

  lbus_irq_encoder u0 (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .busAddr(busAddr),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdEn(busRdEn),
    .busRdData(busRdData), .irqOut(irqOut)
  );

  function automatic logic [15:0] vecOf(logic [15:0] s, logic [15:0] m);
    logic [15:0] p = s & m;
    for (int i = 0; i < 16; i++) if (p[i]) return 16'((i + 1) << 2);
    return 16'h0;
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // Combinational read in mid-cycle, away from any edge
  task automatic rdReg(logic [11:0] a, output logic [15:0] d);
    busAddr = a; busRdEn = 1'b1;
    #1 d = busRdData;
    busRdEn = 1'b0; busAddr = '0;
  endtask

  task automatic wrReg(logic [11:0] a, logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk); #1;
    busWrEn = 1'b0; busAddr = '0;
    if (a == 12'h002) expMask = d;
  endtask

  task automatic setLines(logic [15:0] v);
    @(negedge clk);
    lineIn = v;
    @(posedge clk); #1;
    expSrc = v;
  endtask

  task automatic checkState(string req);
    chk({req, " irq"}, {15'h0, irqOut}, {15'h0, ((expSrc & expMask) != 0)});
    rdReg(12'h000, rd); chk({req, " vec"}, rd, vecOf(expSrc, expMask));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finishRun();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R6 irq in reset", {15'h0, irqOut}, 16'h0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    rdReg(12'h002, rd); chk("R6 mask reset", rd, 16'h0010);
    checkState("R6/R4 reset");

    setLines(16'h0010); checkState("R1/R3 line4 code 20");
    rdReg(12'h000, rd); chk("R3 line4", rd, 16'd20);
    setLines(16'h0008); checkState("R2/R4 masked line3");
    chk("R2 masked no irq", {15'h0, irqOut}, 16'h0);

    wrReg(12'h002, 16'hFFFF);
    checkState("R5 new mask next cycle");
    rdReg(12'h002, rd); chk("R5 mask readback", rd, 16'hFFFF);

    setLines(16'h8000); checkState("R3 line15");
    rdReg(12'h000, rd); chk("R3 line15 code 64", rd, 16'd64);
    setLines(16'h8001); checkState("R3 lowest wins");
    rdReg(12'h000, rd); chk("R3 line0 code 4", rd, 16'd4);
    setLines(16'h0000); checkState("R1 line clear");

    setLines(16'h0300);
    wrReg(12'h004, 16'h0000); checkState("R8 write 0x04");
    wrReg(12'h000, 16'h0000); checkState("R8 write vec offset");
    wrReg(12'h003, 16'h0000);
    rdReg(12'h002, rd); chk("R8 mask unchanged", rd, 16'hFFFF);

    rdReg(12'h004, rd); chk("R7 read 0x04", rd, 16'h0);
    rdReg(12'h001, rd); chk("R7 read 0x01", rd, 16'h0);
    rdReg(12'h003, rd); chk("R7 read 0x03", rd, 16'h0);
    rdReg(12'hFFE, rd); chk("R7 read 0xFFE", rd, 16'h0);
    busAddr = 12'h002; #1;
    chk("R9 idle read data", busRdData, 16'h0);
    busAddr = '0;

    for (int n = 0; n < 300; n++) begin
      logic [15:0] lv;
      logic        doW;
      logic [15:0] mv;
      lv  = 16'($urandom);
      if (n % 3 == 0) lv = lv & 16'($urandom);
      doW = ($urandom % 4) == 0;
      mv  = 16'($urandom);
      @(negedge clk);
      lineIn = lv;
      if (doW) begin busAddr = 12'h002; busWrData = mv; busWrEn = 1'b1; end
      @(posedge clk); #1;
      busWrEn = 1'b0; busAddr = '0;
      expSrc = lv;
      if (doW) expMask = mv;
      checkState("R2/R3 random");
      rdReg(12'h002, rd); chk("R5 random mask", rd, expMask);
    end

    finishRun();
  end

endmodule